// File: doc/BRIEF.md
# Split Nibble Register File

This block holds eight 4-bit registers that can be reached through two views of the same storage. In the narrow view every register has a private read port and a private write port, each with its own enable, so all eight nibbles can be read and written independently in one cycle. In the wide view a single read port and a single write port move the whole file as one 32-bit word. The wide write carries one mask bit per nibble.

Every select is unary: one enable bit per register, with no binary address anywhere. Reads are combinational. A read of a register that is being written in the same cycle returns the incoming value rather than the stored one. Writes land on the next rising clock edge. If a narrow write and a masked wide write hit the same nibble in one cycle, the narrow write takes that nibble, both for storage and for forwarding.

A typical use is a condition or flag file. Execution units update single fields through the narrow ports, and a save, restore or move instruction transfers the whole file through the wide port.

Top module: `nibble_split_rf`

## Requirements
- R1: While the asynchronous active-low reset is low, all eight registers are zero. After release, the internal reset stays active for two more rising edges, and writes are ignored until it deasserts.
- R2: When `nwr_en[i]` is high at a rising edge, register i takes `nwr_d[4i+3:4i]`. No other register changes because of it.
- R3: With `nrd_en[i]` high and no write to register i pending, `nrd_q[4i+3:4i]` shows register i in the same cycle.
- R4: A read port whose enable is low drives zeros: lane i of `nrd_q` when `nrd_en[i]` is low, and all of `wrd_q` when `wrd_en` is low.
- R5: When `wwr_mask[i]` is high at a rising edge (and `nwr_en[i]` is low), register i takes `wwr_d[4i+3:4i]`. Nibbles with a clear mask bit keep their value.
- R6: With `wrd_en` high, `wrd_q[4i+3:4i]` shows register i for every i, nibble 0 in the least significant bits.
- R7: A narrow read of register i in a cycle where a write to register i is enabled returns the data being written.
- R8: Forwarding on the wide read is decided per nibble. Each lane independently returns the in-flight narrow or wide write data for that register.
- R9: When `nwr_en[i]` and `wwr_mask[i]` are both high, the narrow data is stored and is the value forwarded to both read views.
- R10: A register with no write enable at an edge keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| nrd_en | input | 8 | Narrow read enables, bit i for register i |
| nrd_q | output | 32 | Narrow read data, lane i at [4i+3:4i] |
| nwr_en | input | 8 | Narrow write enables, bit i for register i |
| nwr_d | input | 32 | Narrow write data, lane i at [4i+3:4i] |
| wrd_en | input | 1 | Wide read enable |
| wrd_q | output | 32 | Wide read data, nibble i at [4i+3:4i] |
| wwr_mask | input | 8 | Wide write per-nibble mask |
| wwr_d | input | 32 | Wide write data, nibble i at [4i+3:4i] |

## Verification
The assertions check several rules on every cycle:
- disabled ports output zero;
- same-cycle forwarding from the narrow write;
- narrow priority on the wide lane;
- agreement between the two read views on each nibble;
- that a narrow or wide write is visible one cycle later.

The bench's scenarios are needed for the rest:
- the reset value, and the two-edge reset release window;
- that a mask bit leaves unselected nibbles untouched;
- that registers hold their values across idle stretches.

These are shown by comparing every lane against an arithmetic model over thousands of mixed enable patterns.

// File: rtl/nrf_pkg.sv
package nrf_pkg;
  localparam int unsigned NRF_DEF_NUM = 8;
  localparam int unsigned NRF_DEF_W   = 4;

  typedef enum logic [1:0] {
    SRC_HOLD   = 2'd0,
    SRC_NARROW = 2'd1,
    SRC_WIDE   = 2'd2
  } nrf_src_e;
endpackage

// File: rtl/nrf_rst_sync.sv
module nrf_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) stage_q <= 2'b00;
    else           stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_out = stage_q[1];
endmodule

// File: rtl/nrf_wmerge.sv
module nrf_wmerge
  import nrf_pkg::*;
#(
  parameter int unsigned W = NRF_DEF_W
) (
  input  logic         n_en,
  input  logic [W-1:0] n_d,
  input  logic         w_en,
  input  logic [W-1:0] w_d,
  output logic         we,
  output logic [W-1:0] wd
);
  nrf_src_e src;

  always_comb begin
    if (n_en)      src = SRC_NARROW;
    else if (w_en) src = SRC_WIDE;
    else           src = SRC_HOLD;
  end

  always_comb begin
    unique case (src)
      SRC_NARROW: wd = n_d;
      SRC_WIDE:   wd = w_d;
      default:    wd = '0;
    endcase
    we = (src != SRC_HOLD);
  end
endmodule

// File: rtl/nrf_cell.sv
module nrf_cell #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);
  logic [W-1:0] val_q;
  logic [W-1:0] val_d;

  always_comb begin
    val_d = val_q;
    if (we) val_d = wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign q = val_q;
endmodule

// File: rtl/nrf_rdgate.sv
module nrf_rdgate #(
  parameter int unsigned W = 4
) (
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_comb begin
    q = '0;
    if (en) q = d;
  end
endmodule

// File: rtl/nibble_split_rf.sv
module nibble_split_rf
  import nrf_pkg::*;
#(
  parameter int unsigned NUM = NRF_DEF_NUM,
  parameter int unsigned NW  = NRF_DEF_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM-1:0]      nrd_en,
  output logic [NUM*NW-1:0]   nrd_q,
  input  logic [NUM-1:0]      nwr_en,
  input  logic [NUM*NW-1:0]   nwr_d,
  input  logic                wrd_en,
  output logic [NUM*NW-1:0]   wrd_q,
  input  logic [NUM-1:0]      wwr_mask,
  input  logic [NUM*NW-1:0]   wwr_d
);
  localparam int unsigned TOTW = NUM * NW;

  logic            rst_q;
  logic [TOTW-1:0] fwd;

  nrf_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q)
  );

  for (genvar i = 0; i < NUM; i++) begin : g_nib
    logic          we_raw;
    logic          we;
    logic [NW-1:0] wd;
    logic [NW-1:0] cur;

    nrf_wmerge #(.W(NW)) u_merge (
      .n_en (nwr_en[i]),
      .n_d  (nwr_d[i*NW +: NW]),
      .w_en (wwr_mask[i]),
      .w_d  (wwr_d[i*NW +: NW]),
      .we   (we_raw),
      .wd   (wd)
    );

    // writes are blocked while the synchronised reset is held
    assign we = we_raw & rst_q;

    nrf_cell #(.W(NW)) u_cell (
      .clk   (clk),
      .rst_n (rst_q),
      .we    (we),
      .wd    (wd),
      .q     (cur)
    );

    assign fwd[i*NW +: NW] = we ? wd : cur;

    nrf_rdgate #(.W(NW)) u_nrd (
      .en (nrd_en[i]),
      .d  (fwd[i*NW +: NW]),
      .q  (nrd_q[i*NW +: NW])
    );

    nrf_rdgate #(.W(NW)) u_wrd (
      .en (wrd_en),
      .d  (fwd[i*NW +: NW]),
      .q  (wrd_q[i*NW +: NW])
    );
  end
endmodule

// File: rtl/nrf_chk.sv
module nrf_chk #(
  parameter int unsigned NUM = 8,
  parameter int unsigned NW  = 4
) (
  input logic              clk,
  input logic              rst_q,
  input logic [NUM-1:0]    nrd_en,
  input logic [NUM*NW-1:0] nrd_q,
  input logic [NUM-1:0]    nwr_en,
  input logic [NUM*NW-1:0] nwr_d,
  input logic              wrd_en,
  input logic [NUM*NW-1:0] wrd_q,
  input logic [NUM-1:0]    wwr_mask,
  input logic [NUM*NW-1:0] wwr_d
);
  assert_wide_off_zero_R4: assert property (@(posedge clk) disable iff (!rst_q)
    !wrd_en |-> (wrd_q == '0));

  for (genvar i = 0; i < NUM; i++) begin : g_c
    assert_narrow_off_zero_R4: assert property (@(posedge clk) disable iff (!rst_q)
      !nrd_en[i] |-> (nrd_q[i*NW +: NW] == '0));

    assert_narrow_fwd_R7: assert property (@(posedge clk) disable iff (!rst_q)
      (nrd_en[i] && nwr_en[i]) |-> (nrd_q[i*NW +: NW] == nwr_d[i*NW +: NW]));

    assert_wide_fwd_R8: assert property (@(posedge clk) disable iff (!rst_q)
      (wrd_en && wwr_mask[i] && !nwr_en[i]) |-> (wrd_q[i*NW +: NW] == wwr_d[i*NW +: NW]));

    assert_narrow_wins_R9: assert property (@(posedge clk) disable iff (!rst_q)
      (wrd_en && wwr_mask[i] && nwr_en[i]) |-> (wrd_q[i*NW +: NW] == nwr_d[i*NW +: NW]));

    assert_views_agree_R6: assert property (@(posedge clk) disable iff (!rst_q)
      (wrd_en && nrd_en[i]) |-> (wrd_q[i*NW +: NW] == nrd_q[i*NW +: NW]));

    assert_narrow_store_R2: assert property (@(posedge clk) disable iff (!rst_q)
      nwr_en[i] |=> ((nrd_en[i] && !nwr_en[i] && !wwr_mask[i]) ->
                     (nrd_q[i*NW +: NW] == $past(nwr_d[i*NW +: NW]))));

    assert_wide_store_R5: assert property (@(posedge clk) disable iff (!rst_q)
      (wwr_mask[i] && !nwr_en[i]) |=> ((wrd_en && !nwr_en[i] && !wwr_mask[i]) ->
                     (wrd_q[i*NW +: NW] == $past(wwr_d[i*NW +: NW]))));
  end
endmodule

bind nibble_split_rf nrf_chk #(.NUM(NUM), .NW(NW)) u_nrf_chk (
  .clk      (clk),
  .rst_q    (rst_q),
  .nrd_en   (nrd_en),
  .nrd_q    (nrd_q),
  .nwr_en   (nwr_en),
  .nwr_d    (nwr_d),
  .wrd_en   (wrd_en),
  .wrd_q    (wrd_q),
  .wwr_mask (wwr_mask),
  .wwr_d    (wwr_d)
);

// File: tb/test_nibble_split_rf.sv
module test_nibble_split_rf;
  localparam int NUM = 8;
  localparam int NW  = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NUM-1:0]    nrd_en;
  logic [NUM*NW-1:0] nrd_q;
  logic [NUM-1:0]    nwr_en;
  logic [NUM*NW-1:0] nwr_d;
  logic              wrd_en;
  logic [NUM*NW-1:0] wrd_q;
  logic [NUM-1:0]    wwr_mask;
  logic [NUM*NW-1:0] wwr_d;

  int unsigned errors = 0;
  int unsigned checks = 0;
  logic [NW-1:0] mdl [NUM];
  logic [31:0] seed = 32'h1234_5678;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nibble_split_rf i_nibble_split_rf (
    .clk(clk), .rst_n(rst_n),
    .nrd_en(nrd_en), .nrd_q(nrd_q),
    .nwr_en(nwr_en), .nwr_d(nwr_d),
    .wrd_en(wrd_en), .wrd_q(wrd_q),
    .wwr_mask(wwr_mask), .wwr_d(wwr_d)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic chk(input string tag, input logic [NW-1:0] act, input logic [NW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic quiet();
    nrd_en = '0; nwr_en = '0; wrd_en = 1'b0; wwr_mask = '0;
    nwr_d = '0; wwr_d = '0;
  endtask

  // check all lanes against the model, then let the edge happen
  task automatic step(input string nt, input string wt);
    logic [NW-1:0] fv [NUM];
    #1;
    for (int i = 0; i < NUM; i++) begin
      string tg;
      logic [NW-1:0] e;
      if (nwr_en[i])        fv[i] = nwr_d[i*NW +: NW];
      else if (wwr_mask[i]) fv[i] = wwr_d[i*NW +: NW];
      else                  fv[i] = mdl[i];
      e = nrd_en[i] ? fv[i] : '0;
      if (!nrd_en[i])                     tg = "R4";
      else if (nwr_en[i] && wwr_mask[i])  tg = "R9";
      else if (nwr_en[i] || wwr_mask[i])  tg = "R7";
      else                                tg = nt;
      chk(tg, nrd_q[i*NW +: NW], e);
      e = wrd_en ? fv[i] : '0;
      if (!wrd_en)                        tg = "R4";
      else if (nwr_en[i] && wwr_mask[i])  tg = "R9";
      else if (nwr_en[i] || wwr_mask[i])  tg = "R8";
      else                                tg = wt;
      chk(tg, wrd_q[i*NW +: NW], e);
    end
    for (int i = 0; i < NUM; i++) mdl[i] = fv[i];
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    quiet();
    for (int i = 0; i < NUM; i++) mdl[i] = '0;
    @(negedge clk);
    // R1: reset state visible on both views
    nrd_en = '1; wrd_en = 1'b1;
    step("R1", "R1");
    rst_n = 1'b1;
    // R1: writes during the two-edge release window are dropped
    nwr_en = '1; nwr_d = 32'hFFFF_FFFF;
    #1;
    for (int i = 0; i < NUM; i++) chk("R1", wrd_q[i*NW +: NW], '0);
    @(posedge clk); @(negedge clk);
    quiet(); nrd_en = '1; wrd_en = 1'b1;
    for (int i = 0; i < NUM; i++) chk("R1", nrd_q[i*NW +: NW], '0);
    @(posedge clk); @(negedge clk);

    // R2: narrow write of every register, then read back
    quiet(); nwr_en = '1; nwr_d = 32'h8765_4321;
    step("R3", "R6");
    quiet(); nrd_en = '1; wrd_en = 1'b1;
    step("R2", "R6");

    // R5: masked wide write touches only even nibbles
    quiet(); wwr_mask = 8'h55; wwr_d = 32'hFEDC_BA98;
    step("R3", "R6");
    quiet(); nrd_en = '1; wrd_en = 1'b1;
    step("R5", "R5");

    // R10: idle stretch keeps contents
    for (int k = 0; k < 4; k++) begin
      quiet(); nrd_en = 8'hA5; wrd_en = 1'b1;
      step("R10", "R10");
    end

    // R9: narrow and wide collide on nibbles 0..3
    quiet(); nwr_en = 8'h0F; nwr_d = 32'h1111_2222; wwr_mask = 8'hFF; wwr_d = 32'h3333_4444;
    nrd_en = '1; wrd_en = 1'b1;
    step("R3", "R6");
    quiet(); nrd_en = '1; wrd_en = 1'b1;
    step("R9", "R9");

    // sweep: every lane, pseudo-random enable mixes
    for (int k = 0; k < 4000; k++) begin
      seed = nxt(seed); nrd_en = seed[7:0]; nwr_en = seed[15:8] & seed[23:16];
      wrd_en = seed[24];
      seed = nxt(seed); wwr_mask = seed[7:0] & seed[31:24];
      seed = nxt(seed); nwr_d = seed;
      seed = nxt(seed); wwr_d = seed;
      step("R3", "R6");
    end

    // R1: asynchronous reset after traffic
    quiet(); nrd_en = '1; wrd_en = 1'b1;
    #1 rst_n = 1'b0;
    #1;
    for (int i = 0; i < NUM; i++) begin
      chk("R1", nrd_q[i*NW +: NW], '0);
      chk("R1", wrd_q[i*NW +: NW], '0);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule